// File: doc/BRIEF.md
# AHB Bus Cycle Performance Monitor

The monitor sits beside an AHB-Lite slave interface and only listens. For every clock cycle inside a measurement window it decides whether the cycle moved data, was stretched by the slave, or was left unused by the master. It adds one to the counter for that class. Software computes bandwidth, efficiency and utilisation afterwards from the three counts, whose sum is the length of the window.

Before a test, software programs two addresses over an APB port: the address of the first transfer and the address of the last one. It then enables the monitor. The window opens on the accepted address phase of a transfer to the first address. It closes when the data phase of the transfer to the last address completes. After that the counts stay frozen until software clears them or enables the monitor again.

Top module: `ahb_perf_monitor`

## Requirements
- R1: A counted cycle with hsel=1, hready=1 and htrans NONSEQ (2'b10) or SEQ (2'b11) adds one to the data counter, read at APB offset 0x0C.
- R2: A counted cycle with hsel=1 and hready=0 adds one to the slave-busy counter, read at offset 0x10.
- R3: A counted cycle with hready=1 adds one to the master-idle counter, read at offset 0x14, when either hsel=0 or htrans is IDLE (2'b00) or BUSY (2'b01).
- R4: A cycle with hsel=0 and hready=0 changes no counter, even while the window is open.
- R5: No cycle is counted before the window opens. The window opens, and its first cycle is counted, on an accepted address phase (hsel=1, hready=1, htrans[1]=1) whose haddr equals the start address at offset 0x04.
- R6: The accepted transfer whose haddr equals the end address at offset 0x08 arms the close. The first later cycle with hready=1 is still counted and then closes the window. From then on the counts hold, and status at offset 0x18 reads bit0 (window active)=0 and bit1 (window done)=1.
- R7: Writing 1 to control bit1 (offset 0x00) zeroes all three counters and both status bits.
- R8: Each counter stops at its all-ones value instead of wrapping.
- R9: APB writes to the counter offsets (0x0C, 0x10, 0x14) and to status have no effect. Reads of any offset not listed here return zero.
- R10: Control bit0 (enable), the start address and the end address read back as written. pready is always 1 and pslverr is always 0.
- R11: While no counter is saturated, the three counters together grow by exactly one for every window cycle other than those named in R4.
- R12: While enable is 0, the window cannot open and nothing is counted. A write that changes enable from 0 to 1 clears the counters and the window state, as R7 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the observed bus and the APB port |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Observed slave select |
| hready | input | 1 | Observed transfer-ready |
| htrans | input | 2 | Observed transfer type |
| haddr | input | AW | Observed address |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | PAW | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |

## Verification
The hardest case to produce from the ports is a window that closes while the slave still holds the last data phase with wait states. The end transfer must be accepted, then several hready-low cycles must follow, and those must be counted as slave-busy before the closing cycle. The bench plays this exact sequence and checks every counter against fixed numbers. Saturation would take far too long with 32-bit counters, so the bench builds the monitor with 8-bit counters. It then runs long constrained-random streams that reach all-ones while a bench model tracks the expected counts.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam int NUM_CLASSES = 3;
    localparam int CLS_DATA  = 0;
    localparam int CLS_SBUSY = 1;
    localparam int CLS_MIDLE = 2;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_START  = 8'h04;
    localparam logic [7:0] OFS_END    = 8'h08;
    localparam logic [7:0] OFS_DATA   = 8'h0C;
    localparam logic [7:0] OFS_SBUSY  = 8'h10;
    localparam logic [7:0] OFS_MIDLE  = 8'h14;
    localparam logic [7:0] OFS_STATUS = 8'h18;

    typedef struct packed {
        logic active;
        logic done;
        logic end_armed;
    } win_state_t;
endpackage

// File: rtl/pm_classify.sv
module pm_classify
    import perfmon_pkg::*;
(
    input  logic                   hsel,
    input  logic                   hready,
    input  logic [1:0]             htrans,
    output logic [NUM_CLASSES-1:0] cls
);
    always_comb begin
        cls = '0;
        if (hsel && hready && htrans[1])
            cls[CLS_DATA] = 1'b1;
        else if (hsel && !hready)
            cls[CLS_SBUSY] = 1'b1;
        else if (hready)
            cls[CLS_MIDLE] = 1'b1;
    end
endmodule

// File: rtl/pm_window.sv
module pm_window
    import perfmon_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          enable,
    input  logic          hsel,
    input  logic          hready,
    input  logic [1:0]    htrans,
    input  logic [AW-1:0] haddr,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    output logic          count_en,
    output logic          active,
    output logic          done
);
    win_state_t st_d, st_q;
    logic accepted, open_now, live, close_now;

    always_comb begin
        accepted  = hsel && hready && htrans[1];
        open_now  = enable && !st_q.active && !st_q.done && accepted && (haddr == start_addr);
        live      = st_q.active || open_now;
        close_now = enable && st_q.active && st_q.end_armed && hready;
        count_en  = enable && live;

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (enable) begin
            if (open_now)
                st_d.active = 1'b1;
            if (close_now) begin
                st_d.active    = 1'b0;
                st_d.done      = 1'b1;
                st_d.end_armed = 1'b0;
            end else if (live && accepted && (haddr == end_addr)) begin
                st_d.end_armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign done   = st_q.done;

    p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.active);
    p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.active && st_q.end_armed && hready && !clr) |=> (!st_q.active && st_q.done));
    p_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !st_q.active && !clr) |=> !st_q.active);
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt_q));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/ahb_perf_monitor.sv
module ahb_perf_monitor
    import perfmon_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PAW   = 8,
    parameter int CNT_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hsel,
    input  logic           hready,
    input  logic [1:0]     htrans,
    input  logic [AW-1:0]  haddr,
    input  logic           psel,
    input  logic           penable,
    input  logic           pwrite,
    input  logic [PAW-1:0] paddr,
    input  logic [31:0]    pwdata,
    output logic [31:0]    prdata,
    output logic           pready,
    output logic           pslverr
);
    localparam int SUM_W = CNT_W + 2;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] start_addr;
        logic [AW-1:0] end_addr;
    } regs_t;

    regs_t regs_d, regs_q;
    logic wr_en, clr;
    logic [7:0] ofs;
    logic [NUM_CLASSES-1:0] cls;
    logic count_en, win_active, win_done;
    logic [CNT_W-1:0] cnt [NUM_CLASSES];

    assign ofs   = 8'(paddr);
    assign wr_en = psel && penable && pwrite;

    always_comb begin
        regs_d = regs_q;
        clr    = 1'b0;
        if (wr_en) begin
            case (ofs)
                OFS_CTRL: begin
                    regs_d.en = pwdata[0];
                    clr = pwdata[1] || (pwdata[0] && !regs_q.en);
                end
                OFS_START: regs_d.start_addr = AW'(pwdata);
                OFS_END:   regs_d.end_addr   = AW'(pwdata);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    pm_classify u_classify (
        .hsel   (hsel),
        .hready (hready),
        .htrans (htrans),
        .cls    (cls)
    );

    pm_window #(.AW(AW)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .enable     (regs_q.en),
        .hsel       (hsel),
        .hready     (hready),
        .htrans     (htrans),
        .haddr      (haddr),
        .start_addr (regs_q.start_addr),
        .end_addr   (regs_q.end_addr),
        .count_en   (count_en),
        .active     (win_active),
        .done       (win_done)
    );

    for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_cnt
        pm_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (count_en && cls[i]),
            .value (cnt[i])
        );
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            case (ofs)
                OFS_CTRL:   prdata = {31'd0, regs_q.en};
                OFS_START:  prdata = 32'(regs_q.start_addr);
                OFS_END:    prdata = 32'(regs_q.end_addr);
                OFS_DATA:   prdata = 32'(cnt[CLS_DATA]);
                OFS_SBUSY:  prdata = 32'(cnt[CLS_SBUSY]);
                OFS_MIDLE:  prdata = 32'(cnt[CLS_MIDLE]);
                OFS_STATUS: prdata = {30'd0, win_done, win_active};
                default:    prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    logic [SUM_W-1:0] cnt_sum;
    logic any_sat;
    assign cnt_sum = SUM_W'(cnt[0]) + SUM_W'(cnt[1]) + SUM_W'(cnt[2]);
    assign any_sat = (&cnt[0]) || (&cnt[1]) || (&cnt[2]);

    p_sum_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && (|cls) && !clr && !any_sat) |=> (cnt_sum == $past(cnt_sum) + 1'b1));
    p_idle_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsel && !hready && !clr) |=> (cnt_sum == $past(cnt_sum)));
    p_data_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hready && htrans[1]) |-> (cls == 3'b001));
    p_sbusy_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && !hready) |-> (cls == 3'b010));
    p_midle_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && (!hsel || !htrans[1])) |-> (cls == 3'b100));
endmodule

// File: tb/ahb_perf_monitor_test.sv
module ahb_perf_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsel = 1'b0, hready = 1'b0;
    logic [1:0] htrans = 2'b00;
    logic [31:0] haddr = '0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready, pslverr;

    int n_checks = 0;
    int n_fail = 0;

    // bench model state
    bit m_en, m_act, m_done, m_arm;
    int m_cnt [3];
    logic [31:0] m_start, m_end;

    always #(CLK_PERIOD/2) clk = ~clk;

    ahb_perf_monitor #(.AW(32), .PAW(8), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .hready(hready), .htrans(htrans),
        .haddr(haddr), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr)
    );

    function automatic int cls_of(bit hs, bit hr, logic [1:0] ht);
        if (hs && hr && ht[1]) return 0;
        if (hs && !hr) return 1;
        if (hr) return 2;
        return -1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_act = 0; m_done = 0; m_arm = 0;
        for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    endtask

    task automatic ahb_cycle(bit hs, bit hr, logic [1:0] ht, logic [31:0] ha);
        bit acc, opn, live, cls_close;
        int c;
        @(negedge clk);
        hsel = hs; hready = hr; htrans = ht; haddr = ha;
        acc  = hs && hr && ht[1];
        opn  = m_en && !m_act && !m_done && acc && (ha == m_start);
        live = m_act || opn;
        cls_close = m_en && m_act && m_arm && hr;
        if (m_en && live) begin
            c = cls_of(hs, hr, ht);
            if (c >= 0 && m_cnt[c] < CMAX) m_cnt[c]++;
        end
        if (m_en) begin
            if (opn) m_act = 1;
            if (cls_close) begin m_act = 0; m_done = 1; m_arm = 0; end
            else if (live && acc && ha == m_end) m_arm = 1;
        end
    endtask

    task automatic apb_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        hsel = 0; hready = 0;
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        if (a == 8'h00) begin
            if (d[1] || (d[0] && !m_en)) model_clear();
            m_en = d[0];
        end else if (a == 8'h04) m_start = d;
        else if (a == 8'h08) m_end = d;
    endtask

    task automatic apb_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        hsel = 0; hready = 0;
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic check_model(string tag);
        logic [31:0] v;
        apb_read(8'h0C, v); check({tag, " R1 data"}, v, m_cnt[0]);
        apb_read(8'h10, v); check({tag, " R2 sbusy"}, v, m_cnt[1]);
        apb_read(8'h14, v); check({tag, " R3 midle"}, v, m_cnt[2]);
        apb_read(8'h18, v); check({tag, " R6 status"}, v, {30'd0, m_done, m_act});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        m_en = 0; m_start = 0; m_end = 0; model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state
        for (int a = 0; a <= 8'h18; a += 4) begin
            apb_read(8'(a), v);
            check("R10 reset value", v, 32'd0);
        end
        check("R10 pready", {31'd0, pready}, 32'd1);
        check("R10 pslverr", {31'd0, pslverr}, 32'd0);

        // register readback
        apb_write(8'h04, 32'h0000_0200);
        apb_write(8'h08, 32'h0000_0208);
        apb_read(8'h04, v); check("R10 start", v, 32'h200);
        apb_read(8'h08, v); check("R10 end", v, 32'h208);
        apb_read(8'h1C, v); check("R9 unmapped 1C", v, 0);
        apb_read(8'h40, v); check("R9 unmapped 40", v, 0);

        // R12: disabled monitor ignores traffic
        ahb_cycle(1, 1, 2'b10, 32'h200);
        ahb_cycle(1, 1, 2'b11, 32'h204);
        check_model("R12 disabled");
        apb_read(8'h0C, v); check("R12 no count while off", v, 0);

        // directed window with wait states on the end data phase
        apb_write(8'h00, 32'h1);
        apb_read(8'h00, v); check("R10 enable readback", v, 1);
        ahb_cycle(0, 1, 2'b00, 32'h0);        // before window, R5
        ahb_cycle(1, 1, 2'b10, 32'h1F0);      // not start, R5
        ahb_cycle(1, 1, 2'b10, 32'h200);      // opens, data
        ahb_cycle(0, 0, 2'b00, 32'h0);        // R4 uncounted
        ahb_cycle(0, 0, 2'b00, 32'h0);        // R4 uncounted
        ahb_cycle(1, 1, 2'b11, 32'h204);      // data
        ahb_cycle(1, 1, 2'b11, 32'h208);      // data, arms close
        ahb_cycle(1, 0, 2'b00, 32'h0);        // sbusy
        ahb_cycle(1, 0, 2'b00, 32'h0);        // sbusy
        ahb_cycle(1, 1, 2'b00, 32'h0);        // midle, closes
        ahb_cycle(1, 1, 2'b10, 32'h200);      // after close, ignored
        ahb_cycle(1, 0, 2'b10, 32'h204);      // ignored
        apb_read(8'h0C, v); check("R1 R5 data count", v, 3);
        apb_read(8'h10, v); check("R2 R6 sbusy count", v, 2);
        apb_read(8'h14, v); check("R3 R4 midle count", v, 1);
        apb_read(8'h18, v); check("R6 status done", v, 32'h2);

        // R9: writes to counters and status are ignored
        apb_write(8'h0C, 32'hAB);
        apb_write(8'h18, 32'h3);
        apb_read(8'h0C, v); check("R9 counter write ignored", v, 3);
        apb_read(8'h18, v); check("R9 status write ignored", v, 32'h2);

        // R7: clear
        apb_write(8'h00, 32'h3);
        check_model("R7 after clear");
        apb_read(8'h14, v); check("R7 midle cleared", v, 0);

        // random phases, with R8 saturation on long streams
        for (int round = 0; round < 6; round++) begin
            logic [31:0] base;
            int len;
            base = 32'h1000 + 32'(round) * 32'h100;
            apb_write(8'h04, base);
            apb_write(8'h08, base + 32'h3C);
            apb_write(8'h00, 32'h3);
            len = (round < 3) ? 80 : 900;
            for (int k = 0; k < len; k++) begin
                bit hs, hr;
                logic [1:0] ht;
                logic [31:0] ha;
                int r;
                r  = int'($urandom_range(0, 9));
                hs = ($urandom_range(0, 3) != 0);
                hr = ($urandom_range(0, 4) != 0);
                ht = 2'($urandom_range(0, 3));
                if (r == 0) ha = base;
                else if (r == 1 && k > len / 2) ha = base + 32'h3C;
                else ha = base + 32'(4 * $urandom_range(1, 14));
                ahb_cycle(hs, hr, ht, ha);
            end
            check_model("R11 random");
        end

        // R8 directed: saturate data counter
        apb_write(8'h04, 32'h3000);
        apb_write(8'h08, 32'hFFFF_FFF0);
        apb_write(8'h00, 32'h3);
        for (int k = 0; k < CMAX + 20; k++) ahb_cycle(1, 1, 2'b11, 32'h3000 + 32'(4 * k));
        apb_read(8'h0C, v); check("R8 saturated", v, CMAX);
        apb_read(8'h18, v); check("R8 window still open", v, 32'h1);

        // R12: re-enable clears
        apb_write(8'h00, 32'h0);
        apb_read(8'h0C, v); check("R12 held when disabled", v, CMAX);
        apb_write(8'h00, 32'h1);
        apb_read(8'h0C, v); check("R12 enable rise clears", v, 0);
        apb_read(8'h18, v); check("R12 status cleared", v, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule